// File: doc/BRIEF.md
# Low-Power Mode Entry Flags

This block records which deep low-power state the system last went into and makes that record visible through one memory-mapped register. Software first chooses the target of the next deep-sleep request with a mode-select bit: Stop or Standby. When the platform raises its deep-sleep request, the block captures that choice. When the platform then reports, with a one-cycle strobe, that the mode has been entered, the block sets a sticky flag for the captured mode.

Software clears both flags by writing 1 to a command bit. That bit is never stored and always reads back as 0. Two reset inputs act on the flags in different ways. A power-on reset clears everything. A system reset clears the Stop flag and the control state, but it leaves the Standby flag alone. After a warm restart, software can therefore still see that the system came back from Standby.

Top module: `lpm_entry_flags`

## Requirements
- R1: Bit 0 of the register is the mode-select bit (0 = Stop, 1 = Standby). A write stores it and a read returns it. Either reset returns it to 0.
- R2: Bit 1 is the clear command and always reads as 0. A write with bit 1 = 1 clears the Stop and Standby flags at that clock edge.
- R3: Bit 8 is the Stop flag. It is set when Stop is entered and holds until a power-on reset, a system reset or a clear command.
- R4: Bit 9 is the Standby flag. It is set when Standby is entered and holds until a power-on reset or a clear command. A system reset without a power-on reset leaves it unchanged.
- R5: The register answers only at byte address 16. Reads at any other address return 0, and writes there change nothing.
- R6: The target mode is captured in the first cycle of `sleep_req` (from the mode-select bit at that time) and stays fixed while the request stays high. A mode-entered strobe sets the flag of the captured target. A strobe with no request active sets nothing.
- R7: If a flag is being set in the same cycle as a clear command, the set takes effect and the flag ends up at 1.
- R8: All bits other than 0, 8 and 9 read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| sys_rst | input | 1 | System reset, synchronous, active high |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from `reg_addr` |
| sleep_req | input | 1 | Deep-sleep request, level |
| mode_entered | input | 1 | One-cycle strobe: the requested mode has been entered |

## Verification
The bench covers five corner cases.

- **Different reset reach of the two flags.** A design that treated the two flags alike would either lose the Standby flag across a system reset or keep a stale Stop flag.
- **Mode-select bit rewritten during an active request.** A design that read the live bit instead of the captured one would set the wrong flag.
- **Clear command and flag set in the same cycle.** A design where the clear dominates would lose the entry event.
- **Mode-entered strobe with no request active.** A design that did not gate the strobe with the request would set a spurious flag.
- **Out-of-range accesses.** Writes with every bit set and writes to a wrong address expose any decode that leaks into unimplemented bits or answers at a wrong address.

// File: rtl/lpm_flags_pkg.sv
package lpm_flags_pkg;

  typedef enum logic {
    TGT_STOP = 1'b0,
    TGT_STBY = 1'b1
  } lpm_target_e;

  localparam int SEL_BIT   = 0;
  localparam int CLR_BIT   = 1;
  localparam int STOP_BIT  = 8;
  localparam int STBY_BIT  = 9;
  localparam int STATUS_W  = STBY_BIT + 1;

  localparam int NUM_FLAGS = 2;
  localparam int FLAG_STOP = 0;
  localparam int FLAG_STBY = 1;
  // flags that a system reset leaves untouched
  localparam logic [NUM_FLAGS-1:0] FLAG_KEEP_ON_SYS = 2'b10;

  function automatic lpm_target_e pick_target(logic first_cycle, lpm_target_e live,
                                              lpm_target_e held);
    return first_cycle ? live : held;
  endfunction

  // reset over set, set over clear, otherwise hold
  function automatic logic flag_next(logic rst, logic set, logic clr, logic cur);
    if (rst)      return 1'b0;
    else if (set) return 1'b1;
    else if (clr) return 1'b0;
    return cur;
  endfunction

  function automatic logic [STATUS_W-1:0] pack_status(lpm_target_e mode, logic stop,
                                                      logic stby);
    logic [STATUS_W-1:0] s;
    s           = '0;
    s[SEL_BIT]  = mode;
    s[STOP_BIT] = stop;
    s[STBY_BIT] = stby;
    return s;
  endfunction

endpackage

// File: rtl/lpm_req_tracker.sv
module lpm_req_tracker
  import lpm_flags_pkg::*;
(
  input  logic                 clk,
  input  logic                 any_rst,
  input  logic                 sleep_req,
  input  logic                 mode_entered,
  input  lpm_target_e          mode_sel,
  output logic [NUM_FLAGS-1:0] set_vec
);

  logic        req_q;
  lpm_target_e target_q;
  logic        req_first;
  lpm_target_e eff_target;
  logic        entry_hit;

  assign req_first  = sleep_req & ~req_q;
  assign eff_target = pick_target(req_first, mode_sel, target_q);
  assign entry_hit  = sleep_req & mode_entered & ~any_rst;

  always_ff @(posedge clk) begin
    if (any_rst) begin
      req_q    <= 1'b0;
      target_q <= TGT_STOP;
    end else begin
      req_q <= sleep_req;
      if (req_first) target_q <= mode_sel;
    end
  end

  assign set_vec[FLAG_STOP] = entry_hit & (eff_target == TGT_STOP);
  assign set_vec[FLAG_STBY] = entry_hit & (eff_target == TGT_STBY);

  // R6: captured target does not move while the request is held
  assert_target_held_R6: assert property (@(posedge clk) disable iff (any_rst)
    (sleep_req && req_q) |=> $stable(target_q));

  // R6: no flag set without an active request
  assert_no_idle_set_R6: assert property (@(posedge clk) disable iff (any_rst)
    !sleep_req |-> (set_vec == '0));

  assert_single_target_R6: assert property (@(posedge clk) disable iff (any_rst)
    $onehot0(set_vec));

endmodule

// File: rtl/lpm_flag_bank.sv
module lpm_flag_bank
  import lpm_flags_pkg::*;
#(
  parameter logic [NUM_FLAGS-1:0] KEEP_ON_SYS = FLAG_KEEP_ON_SYS
) (
  input  logic                 clk,
  input  logic                 por,
  input  logic                 sys_rst,
  input  logic [NUM_FLAGS-1:0] set_vec,
  input  logic                 clear_cmd,
  output logic [NUM_FLAGS-1:0] flags
);

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    logic flag_rst;

    if (KEEP_ON_SYS[g]) begin : g_cold_only
      assign flag_rst = por;
    end else begin : g_any_reset
      assign flag_rst = por | sys_rst;
    end

    always_ff @(posedge clk) begin
      flags[g] <= flag_next(flag_rst, set_vec[g], clear_cmd, flags[g]);
    end

    // R7: a set in the same cycle as a clear still leaves the flag at 1
    assert_set_over_clear_R7: assert property (@(posedge clk) disable iff (flag_rst)
      (set_vec[g] && clear_cmd) |=> flags[g]);

    // R3, R4: flags stay set without a clear or a reset that reaches them
    assert_sticky_R3_R4: assert property (@(posedge clk) disable iff (flag_rst)
      (flags[g] && !clear_cmd) |=> flags[g]);
  end

endmodule

// File: rtl/lpm_regif.sv
module lpm_regif
  import lpm_flags_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int REG_OFFSET = 16
) (
  input  logic              clk,
  input  logic              any_rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              stop_flag,
  input  logic              stby_flag,
  output logic [DATA_W-1:0] reg_rdata,
  output lpm_target_e       mode_sel,
  output logic              clear_cmd
);

  localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'(pack_status(TGT_STBY, 1'b1, 1'b1));

  logic addr_hit;
  logic wr_hit;
  logic unused_wdata;

  assign addr_hit     = (reg_addr == ADDR_W'(REG_OFFSET));
  assign wr_hit       = addr_hit & reg_wr_en;
  assign clear_cmd    = wr_hit & reg_wdata[CLR_BIT];
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (any_rst)     mode_sel <= TGT_STOP;
    else if (wr_hit) mode_sel <= lpm_target_e'(reg_wdata[SEL_BIT]);
  end

  assign reg_rdata = addr_hit ? DATA_W'(pack_status(mode_sel, stop_flag, stby_flag)) : '0;

  assert_clr_reads_zero_R2: assert property (@(posedge clk) disable iff (any_rst)
    reg_rdata[CLR_BIT] == 1'b0);

  assert_miss_reads_zero_R5: assert property (@(posedge clk) disable iff (any_rst)
    !addr_hit |-> (reg_rdata == '0));

  assert_unimpl_zero_R8: assert property (@(posedge clk) disable iff (any_rst)
    (reg_rdata & ~IMPL_MASK) == '0);

  // R1: a write at the register address is reflected on the next cycle
  assert_mode_write_R1: assert property (@(posedge clk) disable iff (any_rst)
    wr_hit |=> (mode_sel == lpm_target_e'($past(reg_wdata[SEL_BIT]))));

endmodule

// File: rtl/lpm_entry_flags.sv
module lpm_entry_flags
  import lpm_flags_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int REG_OFFSET = 16
) (
  input  logic              clk,
  input  logic              por,
  input  logic              sys_rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sleep_req,
  input  logic              mode_entered
);

  logic                 any_rst;
  lpm_target_e          mode_sel;
  logic                 clear_cmd;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flags;
  logic                 stop_flag;
  logic                 stby_flag;

  assign any_rst   = por | sys_rst;
  assign stop_flag = flags[FLAG_STOP];
  assign stby_flag = flags[FLAG_STBY];

  lpm_regif #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .REG_OFFSET(REG_OFFSET)
  ) u_regif (
    .clk       (clk),
    .any_rst   (any_rst),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .stop_flag (stop_flag),
    .stby_flag (stby_flag),
    .reg_rdata (reg_rdata),
    .mode_sel  (mode_sel),
    .clear_cmd (clear_cmd)
  );

  lpm_req_tracker u_tracker (
    .clk         (clk),
    .any_rst     (any_rst),
    .sleep_req   (sleep_req),
    .mode_entered(mode_entered),
    .mode_sel    (mode_sel),
    .set_vec     (set_vec)
  );

  lpm_flag_bank #(
    .KEEP_ON_SYS(FLAG_KEEP_ON_SYS)
  ) u_flags (
    .clk      (clk),
    .por      (por),
    .sys_rst  (sys_rst),
    .set_vec  (set_vec),
    .clear_cmd(clear_cmd),
    .flags    (flags)
  );

  assert_stop_drops_on_sysrst_R3: assert property (@(posedge clk) disable iff (por)
    sys_rst |=> !stop_flag);

  assert_stby_survives_sysrst_R4: assert property (@(posedge clk) disable iff (por)
    (sys_rst && stby_flag && !clear_cmd) |=> stby_flag);

  assert_mode_cleared_R1: assert property (@(posedge clk) disable iff (por)
    sys_rst |=> (mode_sel == TGT_STOP));

  assert_clear_effect_R2: assert property (@(posedge clk) disable iff (any_rst)
    (clear_cmd && set_vec == '0) |=> (flags == '0));

endmodule

// File: tb/sim_lpm_entry_flags.sv
`timescale 1ns/1ps
module sim_lpm_entry_flags;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int OFF = 16;

  logic          clk = 1'b0;
  logic          por = 1'b1;
  logic          sys_rst = 1'b0;
  logic [AW-1:0] addr = AW'(OFF);
  logic          wr_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          sleep_req = 1'b0;
  logic          mode_entered = 1'b0;
  wire  [DW-1:0] rdata;

  always #2 clk = ~clk;

  lpm_entry_flags #(.ADDR_W(AW), .DATA_W(DW), .REG_OFFSET(OFF)) u0 (
    .clk(clk), .por(por), .sys_rst(sys_rst), .reg_addr(addr), .reg_wr_en(wr_en),
    .reg_wdata(wdata), .reg_rdata(rdata), .sleep_req(sleep_req),
    .mode_entered(mode_entered)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string cur = "R1";

  // behavioural reference state
  int m_mode = 0, m_stop = 0, m_stby = 0, m_prev = 0, m_tgt = 0;

  task automatic model_edge();
    int anyr, hit, wr, clr, first, tgt, s_stop, s_stby;
    anyr   = (por || sys_rst) ? 1 : 0;
    hit    = (addr == AW'(OFF)) ? 1 : 0;
    wr     = (hit != 0 && wr_en) ? 1 : 0;
    clr    = (wr != 0 && wdata[1]) ? 1 : 0;
    first  = (sleep_req && m_prev == 0) ? 1 : 0;
    tgt    = (first != 0) ? m_mode : m_tgt;
    s_stop = (anyr == 0 && sleep_req && mode_entered && tgt == 0) ? 1 : 0;
    s_stby = (anyr == 0 && sleep_req && mode_entered && tgt == 1) ? 1 : 0;
    if (anyr != 0) m_stop = 0; else if (s_stop != 0) m_stop = 1; else if (clr != 0) m_stop = 0;
    if (por) m_stby = 0; else if (s_stby != 0) m_stby = 1; else if (clr != 0) m_stby = 0;
    if (anyr != 0) begin
      m_mode = 0; m_tgt = 0; m_prev = 0;
    end else begin
      if (wr != 0) m_mode = wdata[0] ? 1 : 0;
      if (first != 0) m_tgt = m_mode_before(tgt);
      m_prev = sleep_req ? 1 : 0;
    end
  endtask

  function automatic int m_mode_before(int t);
    return t;
  endfunction

  function automatic logic [DW-1:0] expect_rd();
    if (addr != AW'(OFF)) return '0;
    return DW'((m_stby << 9) | (m_stop << 8) | m_mode);
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(cur, rdata, expect_rd());
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0; wdata = '0; addr = AW'(OFF);
  endtask

  task automatic enter_mode();
    sleep_req = 1'b1; tick();
    mode_entered = 1'b1; tick();
    mode_entered = 1'b0; sleep_req = 1'b0; tick();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    // reset state
    cur = "R1";
    tick(); tick(); tick();
    chk("R1", rdata, 32'h0);
    por = 1'b0; tick();
    wr(AW'(OFF), 32'h1); chk("R1", rdata, 32'h1);
    wr(AW'(OFF), 32'h0); chk("R1", rdata, 32'h0);

    // Stop entry
    cur = "R3";
    enter_mode(); chk("R3", rdata, 32'h100);

    // clear command, bit 1 reads 0
    cur = "R2";
    wr(AW'(OFF), 32'h2); chk("R2", rdata, 32'h0);

    // Standby entry with request and strobe in the same first cycle
    cur = "R4";
    wr(AW'(OFF), 32'h1);
    sleep_req = 1'b1; mode_entered = 1'b1; tick();
    mode_entered = 1'b0; sleep_req = 1'b0; tick();
    chk("R4", rdata, 32'h201);
    wr(AW'(OFF), 32'h0);
    enter_mode(); chk("R4", rdata, 32'h300);
    // system reset: Stop cleared, Standby kept
    sys_rst = 1'b1; tick(); tick();
    sys_rst = 1'b0; tick();
    chk("R4", rdata, 32'h200);
    chk("R3", {31'b0, rdata[8]}, 32'h0);
    // power-on reset clears everything
    cur = "R1";
    por = 1'b1; tick(); tick();
    por = 1'b0; tick();
    chk("R4", rdata, 32'h0);

    // target captured at request start
    cur = "R6";
    sleep_req = 1'b1; tick();
    wr(AW'(OFF), 32'h1);
    mode_entered = 1'b1; tick();
    mode_entered = 1'b0; sleep_req = 1'b0; tick();
    chk("R6", rdata, 32'h101);
    wr(AW'(OFF), 32'h3); chk("R2", rdata, 32'h1);
    // strobe with no request
    mode_entered = 1'b1; tick();
    mode_entered = 1'b0; tick();
    chk("R6", rdata, 32'h1);

    // set and clear in the same cycle
    cur = "R7";
    sleep_req = 1'b1; tick();
    addr = AW'(OFF); wdata = 32'h2; wr_en = 1'b1; mode_entered = 1'b1; tick();
    wr_en = 1'b0; wdata = '0; mode_entered = 1'b0; sleep_req = 1'b0; tick();
    chk("R7", rdata, 32'h200);

    // other addresses
    cur = "R5";
    addr = AW'(20); wdata = 32'h3; wr_en = 1'b1; tick();
    chk("R5", rdata, 32'h0);
    wr_en = 1'b0; wdata = '0; addr = AW'(OFF); tick();
    chk("R5", rdata, 32'h200);

    // unimplemented bits
    cur = "R8";
    wr(AW'(OFF), 32'hFFFF_FCFC); chk("R8", rdata, 32'h200);
    wr(AW'(OFF), 32'hFFFF_FFFD); chk("R8", rdata, 32'h201);

    summary();
    $finish;
  end
endmodule